// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the two data-line levels of a USB low-speed link into a stream of received bytes. The D+ and D- levels arrive already synchronised to the system clock. The receiver waits for the bus to go idle. It then hunts for the alternating sync field and locks onto the pair of K bits that close it. From that point it samples every bit near its centre. The sample point comes from a phase accumulator that advances by the bit rate on each clock. Because of this, a bit period that is not a whole number of clocks is met on average: the accumulator adds a leap clock in a fixed, repeating pattern.

Each sample is NRZI-decoded. A bit is dropped when it follows six decoded ones, and the level of that dropped bit becomes the new reference for decoding. The block packs the remaining bits into bytes, least significant bit first, and presents each byte with a one-cycle strobe. An SE0 sample ends the packet and reports its length, together with an overflow flag if the packet carried more bytes than the limit. An SE1 sample drops the packet. A sync attempt that loses the K edge during retry is counted as a frame error.

Controller states and transitions: `ST_IDLE_WAIT` goes to `ST_FIRST_K` once D- is high. `ST_FIRST_K` goes to `ST_CONFIRM` on a K and restarts the bit timer; this wait has no time limit. `ST_CONFIRM` skips the mid-bit sample of the first K and takes the next one. A K there goes to `ST_DATA` and a J goes to `ST_RETRY_K`. `ST_RETRY_K` goes back to `ST_CONFIRM` on a K and restarts the timer. If RETRY_BITS samples pass without a K, it goes to `ST_IDLE_WAIT` and raises the frame error. `ST_DATA` goes to `ST_IDLE_WAIT` on an SE0 sample, which ends the packet, or on an SE1 sample, which aborts it.

Top module: `usb_ls_rx`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, byte_valid, pkt_end, pkt_overflow and sof_err are 0, and pkt_len and sof_cnt are 0.
- R2: A packet starts only after two consecutive K samples. A K that is followed one bit later by J produces no byte and no pkt_end. A well-formed sync field never raises sof_err.
- R3: After a failed confirmation, if no K appears within RETRY_BITS bit periods, sof_err pulses for one cycle and sof_cnt increases by one.
- R4: Line states are {D+,D-}: J = 01, K = 10, SE0 = 00, SE1 = 11. A data sample with the same J/K state as the reference decodes as 1. A different state decodes as 0 and becomes the new reference.
- R5: The bit after six consecutive decoded ones is discarded, and its line state becomes the reference. This holds both inside a byte and at a byte boundary.
- R6: Bits fill bytes LSB first. Each complete byte appears on byte_data with byte_valid high for exactly one cycle.
- R7: An SE0 sample in a packet gives a one-cycle pulse on pkt_end, and pkt_len holds the number of bytes emitted in that packet.
- R8: Bytes beyond MAX_BYTES are not emitted. pkt_overflow pulses together with pkt_end when this happened, and only then. A packet of exactly MAX_BYTES bytes does not overflow.
- R9: An SE1 sample in a packet ends reception with no pkt_end. The next sync field is received normally.
- R10: Consecutive sample strobes are floor(CLK_HZ/BIT_HZ) or that value plus one clocks apart, so a MAX_BYTES-byte packet decodes without drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dp | input | 1 | Synchronised D+ level |
| line_dm | input | 1 | Synchronised D- level |
| byte_data | output | 8 | Last received byte |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| pkt_end | output | 1 | One-cycle strobe at SE0 end of packet |
| pkt_overflow | output | 1 | Set with pkt_end when bytes were dropped |
| pkt_len | output | $clog2(MAX_BYTES+1) | Byte count of the last ended packet |
| sof_err | output | 1 | One-cycle strobe on a lost sync attempt |
| sof_cnt | output | SOF_CNT_W | Running count of lost sync attempts |

## Verification
Several properties are checked on every cycle. Strobe spacing stays within one clock of the ideal period. Byte, end and error strobes last one cycle. Overflow is only ever flagged with an end of packet. An SE0 or SE1 sample in a packet leads to the correct exit, and each frame error advances the counter by one. Other behaviour can only be shown by the bench scenarios: decoded byte values, stuff-bit removal at different positions, correct locking after an alternating sync field, the exact length and overflow limit, and recovery after an aborted packet.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_WAIT = 3'd0,
        ST_FIRST_K   = 3'd1,
        ST_CONFIRM   = 3'd2,
        ST_RETRY_K   = 3'd3,
        ST_DATA      = 3'd4
    } rx_state_e;

    // Encoded as {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned BIT_HZ = 1_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign,
    output logic strobe
);
    localparam int unsigned ACC_W = $clog2(CLK_HZ) + 2;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(BIT_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(CLK_HZ / 2);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = acc_q + STEP;

    // Fractional period: a wrap past WRAP leaves a remainder, which
    // stretches some periods by one leap clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            strobe <= 1'b0;
        end else if (realign) begin
            acc_q  <= HALF;
            strobe <= 1'b0;
        end else if (acc_sum >= WRAP) begin
            acc_q  <= acc_sum - WRAP;
            strobe <= 1'b1;
        end else begin
            acc_q  <= acc_sum;
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_ls_nrzi_unstuff.sv
module usb_ls_nrzi_unstuff #(
    parameter int unsigned STUFF_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_ref,
    input  logic smp_en,
    input  logic line_j,
    output logic bit_vld,
    output logic bit_val
);
    localparam int unsigned RUN_W = $clog2(STUFF_LEN + 1);

    logic             ref_j_q;
    logic [RUN_W-1:0] run_q;
    logic             same;

    assign same = (line_j == ref_j_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_j_q <= 1'b1;
            run_q   <= '0;
            bit_vld <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            bit_vld <= 1'b0;
            if (load_ref) begin
                ref_j_q <= 1'b0;            // sync closes on K
                run_q   <= '0;
            end else if (smp_en) begin
                ref_j_q <= line_j;          // every sample, stuffed or not, is the new reference
                if (run_q == RUN_W'(STUFF_LEN)) begin
                    run_q <= '0;
                end else begin
                    bit_vld <= 1'b1;
                    bit_val <= same;
                    run_q   <= same ? run_q + 1'b1 : '0;
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_byte_pack.sv
module usb_ls_byte_pack #(
    parameter int unsigned MAX_BYTES = 11,
    parameter int unsigned LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_vld,
    input  logic             bit_val,
    output logic [7:0]       byte_data,
    output logic             byte_valid,
    output logic [LEN_W-1:0] count,
    output logic             ovf
);
    logic [7:0] shreg_q;
    logic [2:0] nbit_q;
    logic [7:0] shreg_d;

    assign shreg_d = {bit_val, shreg_q[7:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            nbit_q     <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            count      <= '0;
            ovf        <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (clear) begin
                shreg_q <= '0;
                nbit_q  <= '0;
                count   <= '0;
                ovf     <= 1'b0;
            end else if (bit_vld) begin
                shreg_q <= shreg_d;
                nbit_q  <= nbit_q + 3'd1;
                if (nbit_q == 3'd7) begin
                    if (count < LEN_W'(MAX_BYTES)) begin
                        byte_data  <= shreg_d;
                        byte_valid <= 1'b1;
                        count      <= count + 1'b1;
                    end else begin
                        ovf <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned BIT_HZ     = 1_500_000,
    parameter int unsigned MAX_BYTES  = 11,
    parameter int unsigned STUFF_LEN  = 6,
    parameter int unsigned RETRY_BITS = 4,
    parameter int unsigned SOF_CNT_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             line_dp,
    input  logic                             line_dm,
    output logic [7:0]                       byte_data,
    output logic                             byte_valid,
    output logic                             pkt_end,
    output logic                             pkt_overflow,
    output logic [$clog2(MAX_BYTES+1)-1:0]   pkt_len,
    output logic                             sof_err,
    output logic [SOF_CNT_W-1:0]             sof_cnt
);
    localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1);
    localparam int unsigned WIN_W = $clog2(RETRY_BITS + 1);

    line_e      line_s;
    logic       is_k;
    logic       is_j;
    rx_state_e  state_q;
    rx_state_e  state_d;
    logic       strobe;
    logic       realign;
    logic       accept_sync;
    logic       end_hit;
    logic       sof_hit;
    logic       smp_en;
    logic       half_seen_q;
    logic [WIN_W-1:0] win_q;
    logic       bit_vld;
    logic       bit_val;
    logic [LEN_W-1:0] byte_cnt;
    logic       byte_ovf;

    assign line_s = line_e'({line_dp, line_dm});
    assign is_k   = (line_s == LN_K);
    assign is_j   = (line_s == LN_J);
    assign smp_en = (state_q == ST_DATA) && strobe && (is_j || is_k);

    usb_ls_bit_timer #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (realign),
        .strobe  (strobe)
    );

    usb_ls_nrzi_unstuff #(.STUFF_LEN(STUFF_LEN)) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ref (accept_sync),
        .smp_en   (smp_en),
        .line_j   (is_j),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val)
    );

    usb_ls_byte_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept_sync),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .count      (byte_cnt),
        .ovf        (byte_ovf)
    );

    // Next-state decision
    always_comb begin
        state_d     = state_q;
        realign     = 1'b0;
        accept_sync = 1'b0;
        end_hit     = 1'b0;
        sof_hit     = 1'b0;
        unique case (state_q)
            ST_IDLE_WAIT: begin
                if (line_dm) state_d = ST_FIRST_K;
            end
            ST_FIRST_K: begin
                if (is_k) begin
                    realign = 1'b1;
                    state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (strobe && half_seen_q) begin
                    if (is_k) begin
                        accept_sync = 1'b1;
                        state_d     = ST_DATA;
                    end else begin
                        state_d = ST_RETRY_K;
                    end
                end
            end
            ST_RETRY_K: begin
                if (is_k) begin
                    realign = 1'b1;
                    state_d = ST_CONFIRM;
                end else if (strobe && (win_q == WIN_W'(RETRY_BITS - 1))) begin
                    sof_hit = 1'b1;
                    state_d = ST_IDLE_WAIT;
                end
            end
            ST_DATA: begin
                if (strobe) begin
                    if (line_s == LN_SE0) begin
                        end_hit = 1'b1;
                        state_d = ST_IDLE_WAIT;
                    end else if (line_s == LN_SE1) begin
                        state_d = ST_IDLE_WAIT;
                    end
                end
            end
            default: state_d = ST_IDLE_WAIT;
        endcase
    end

    // State register and its sequencing helpers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE_WAIT;
            half_seen_q <= 1'b0;
            win_q       <= '0;
        end else begin
            state_q <= state_d;
            if (realign)
                half_seen_q <= 1'b0;
            else if (state_q == ST_CONFIRM && strobe)
                half_seen_q <= 1'b1;
            if (state_q != ST_RETRY_K)
                win_q <= '0;
            else if (strobe)
                win_q <= win_q + 1'b1;
        end
    end

    // Registered packet and error outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_end      <= 1'b0;
            pkt_overflow <= 1'b0;
            pkt_len      <= '0;
            sof_err      <= 1'b0;
            sof_cnt      <= '0;
        end else begin
            pkt_end      <= end_hit;
            pkt_overflow <= end_hit && byte_ovf;
            sof_err      <= sof_hit;
            if (end_hit) pkt_len <= byte_cnt;
            if (sof_hit) sof_cnt <= sof_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk
    import usb_ls_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned BIT_HZ    = 1_500_000,
    parameter int unsigned MAX_BYTES = 11,
    parameter int unsigned SOF_CNT_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           line_dp,
    input logic                           line_dm,
    input rx_state_e                      state_q,
    input logic                           strobe,
    input logic                           realign,
    input logic                           byte_valid,
    input logic                           pkt_end,
    input logic                           pkt_overflow,
    input logic [$clog2(MAX_BYTES+1)-1:0] pkt_len,
    input logic                           sof_err,
    input logic [SOF_CNT_W-1:0]           sof_cnt
);
    localparam int unsigned GAP_LO = CLK_HZ / BIT_HZ;
    localparam int unsigned GAP_HI = GAP_LO + 1;

    logic [15:0] gap_q;
    logic        armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (realign) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (strobe) begin
            gap_q   <= 16'd1;
            armed_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 16'd1;
        end
    end

    assert_strobe_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && armed_q) |-> (gap_q >= 16'(GAP_LO) && gap_q <= 16'(GAP_HI)));

    assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_byte_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (state_q == ST_DATA));

    assert_end_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    assert_se0_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && strobe && !line_dp && !line_dm) |=> pkt_end);

    assert_ovf_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_overflow |-> pkt_end);

    assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (pkt_len <= ($clog2(MAX_BYTES+1))'(MAX_BYTES)));

    assert_se1_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && strobe && line_dp && line_dm)
        |=> (state_q == ST_IDLE_WAIT && !pkt_end));

    assert_sof_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_err |=> !sof_err);

    assert_sof_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_err) |-> (sof_cnt == $past(sof_cnt) + 1'b1));
endmodule

bind usb_ls_rx usb_ls_rx_chk #(
    .CLK_HZ    (CLK_HZ),
    .BIT_HZ    (BIT_HZ),
    .MAX_BYTES (MAX_BYTES),
    .SOF_CNT_W (SOF_CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_dp      (line_dp),
    .line_dm      (line_dm),
    .state_q      (state_q),
    .strobe       (strobe),
    .realign      (realign),
    .byte_valid   (byte_valid),
    .pkt_end      (pkt_end),
    .pkt_overflow (pkt_overflow),
    .pkt_len      (pkt_len),
    .sof_err      (sof_err),
    .sof_cnt      (sof_cnt)
);

// File: tb/usb_ls_rx_tb_top.sv
`timescale 1ns/1ps
module usb_ls_rx_tb_top;
    localparam int unsigned CLK_HZ    = 100_000_000;
    localparam int unsigned BIT_HZ    = 1_500_000;
    localparam int unsigned MAX_BYTES = 11;
    localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1);

    // Stimulus table: payload bytes and their count
    localparam logic [7:0] VEC_BYTES [4][3] = '{
        '{8'hA5, 8'h3C, 8'h01},   // mixed patterns
        '{8'hFF, 8'hFF, 8'h00},   // long runs of ones
        '{8'hFC, 8'h81, 8'h7E},   // stuff at byte end and inside a byte
        '{8'h96, 8'h00, 8'h00}    // single byte
    };
    localparam int VEC_LEN [4] = '{3, 3, 3, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b0;
    logic dm = 1'b1;
    logic [7:0]       byte_data;
    logic             byte_valid;
    logic             pkt_end;
    logic             pkt_overflow;
    logic [LEN_W-1:0] pkt_len;
    logic             sof_err;
    logic [7:0]       sof_cnt;

    always #5 clk = ~clk;

    usb_ls_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_dp      (dp),
        .line_dm      (dm),
        .byte_data    (byte_data),
        .byte_valid   (byte_valid),
        .pkt_end      (pkt_end),
        .pkt_overflow (pkt_overflow),
        .pkt_len      (pkt_len),
        .sof_err      (sof_err),
        .sof_cnt      (sof_cnt)
    );

    int n_checks = 0;
    int n_errs   = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    endtask

    // Monitor, sampled away from the active edge
    logic [7:0] rx_q[$];
    int   end_cnt = 0;
    int   ovf_cnt = 0;
    int   sof_pulses = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) rx_q.push_back(byte_data);
            if (pkt_end) end_cnt++;
            if (pkt_overflow) ovf_cnt++;
            if (sof_err) sof_pulses++;
        end
    end

    task automatic clear_mon();
        rx_q.delete();
        end_cnt = 0;
        ovf_cnt = 0;
        sof_pulses = 0;
    endtask

    // Bit slots follow the exact fractional period
    longint bit_idx = 0;
    task automatic hold_bit(input logic p, input logic m);
        longint n;
        dp = p;
        dm = m;
        n = ((bit_idx + 1) * longint'(CLK_HZ)) / longint'(BIT_HZ)
            - (bit_idx * longint'(CLK_HZ)) / longint'(BIT_HZ);
        bit_idx++;
        repeat (int'(n)) @(negedge clk);
    endtask

    logic [7:0] tx_q[$];

    task automatic send_frame(input bit se1_end);
        logic cur;
        int   run;
        for (int s = 0; s < 3; s++) begin
            hold_bit(1'b1, 1'b0);
            hold_bit(1'b0, 1'b1);
        end
        hold_bit(1'b1, 1'b0);
        hold_bit(1'b1, 1'b0);
        cur = 1'b1;
        run = 0;
        foreach (tx_q[i]) begin
            for (int b = 0; b < 8; b++) begin
                if (tx_q[i][b]) run++;
                else begin
                    cur = ~cur;
                    run = 0;
                end
                hold_bit(cur, ~cur);
                if (run == 6) begin
                    cur = ~cur;
                    run = 0;
                    hold_bit(cur, ~cur);
                end
            end
        end
        if (se1_end) begin
            hold_bit(1'b1, 1'b1);
            hold_bit(1'b1, 1'b1);
        end else begin
            hold_bit(1'b0, 1'b0);
            hold_bit(1'b0, 1'b0);
        end
        for (int s = 0; s < 4; s++) hold_bit(1'b0, 1'b1);
    endtask

    task automatic check_bytes(input string tag);
        chk({tag, " byte count"}, rx_q.size(), tx_q.size());
        foreach (tx_q[k])
            if (k < rx_q.size()) chk({tag, " byte value"}, rx_q[k], tx_q[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual running expected finished");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 byte_valid in reset", byte_valid, 0);
        chk("R1 pkt_end in reset", pkt_end, 0);
        chk("R1 pkt_len in reset", pkt_len, 0);
        chk("R1 sof_cnt in reset", sof_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sof_err after reset", sof_err, 0);
        chk("R1 pkt_overflow after reset", pkt_overflow, 0);
        repeat (4) @(negedge clk);

        // Table walk: R4 R5 R6 R7
        for (int v = 0; v < 4; v++) begin
            clear_mon();
            tx_q.delete();
            for (int k = 0; k < VEC_LEN[v]; k++) tx_q.push_back(VEC_BYTES[v][k]);
            send_frame(1'b0);
            check_bytes(v == 0 ? "R4 R6" : (v == 3 ? "R6" : "R5"));
            chk("R7 one pkt_end", end_cnt, 1);
            chk("R7 pkt_len", pkt_len, VEC_LEN[v]);
            chk("R8 no overflow", ovf_cnt, 0);
        end
        chk("R2 clean syncs give no sof_err", sof_cnt, 0);

        // Exactly MAX_BYTES bytes: no overflow, no drift (R8, R10)
        clear_mon();
        tx_q.delete();
        for (int k = 0; k < MAX_BYTES; k++) tx_q.push_back(8'(8'h11 * k + 8'h0F));
        send_frame(1'b0);
        check_bytes("R10 long packet");
        chk("R8 full packet length", pkt_len, MAX_BYTES);
        chk("R8 full packet no overflow", ovf_cnt, 0);

        // One byte too many
        clear_mon();
        tx_q.delete();
        for (int k = 0; k <= MAX_BYTES; k++) tx_q.push_back(8'(k + 1));
        send_frame(1'b0);
        chk("R8 bytes emitted", rx_q.size(), MAX_BYTES);
        chk("R8 last emitted byte", rx_q.size() > 0 ? rx_q[rx_q.size()-1] : 0, MAX_BYTES);
        chk("R8 overflow flagged", ovf_cnt, 1);
        chk("R8 end with overflow", end_cnt, 1);
        chk("R8 capped length", pkt_len, MAX_BYTES);

        // Lone K then idle: no packet, frame error (R2, R3)
        clear_mon();
        hold_bit(1'b1, 1'b0);
        for (int s = 0; s < 8; s++) hold_bit(1'b0, 1'b1);
        chk("R2 lone K gives no byte", rx_q.size(), 0);
        chk("R2 lone K gives no pkt_end", end_cnt, 0);
        chk("R3 one sof_err pulse", sof_pulses, 1);
        chk("R3 sof_cnt advanced", sof_cnt, 1);

        // SE1 abort, then recovery (R9)
        clear_mon();
        tx_q.delete();
        tx_q.push_back(8'h5A);
        send_frame(1'b1);
        chk("R9 no pkt_end on SE1", end_cnt, 0);
        chk("R9 byte before SE1", rx_q.size(), 1);
        clear_mon();
        tx_q.delete();
        tx_q.push_back(8'h42);
        send_frame(1'b0);
        check_bytes("R9 after abort");
        chk("R9 pkt_end after abort", end_cnt, 1);
        chk("R9 length after abort", pkt_len, 1);

        report();
        $finish;
    end
endmodule